// File: doc/BRIEF.md
# Masked Block Write Engine for an Open Graphics-Memory Row

This block models one open row of a graphics memory, 256 columns of 32 bits, together with the write datapath that fills it. Two internal registers, a color value and a per-bit write mask, are loaded through dedicated register-load commands. A normal write stores the data bus into one column. A block write stores the color value into an aligned group of eight columns in a single command. The data bus then carries a column-enable pattern rather than data.

Byte-lane masks on the `dqm` pins apply to both write kinds. When the row was opened with per-bit masking requested, both write kinds also leave unchanged every bit that is 0 in the mask register. A combinational read port returns any column so that a bench or a neighbouring block can inspect the row.

Top module: `blkwr_engine`

## Requirements
- R1: While `rst_n` is low, every column, the color register and the per-bit masking flag clear to 0 and the mask register sets to all ones. After reset, every column reads back 0.
- R2: `cmd` is sampled on each rising edge. The codes are 0 no-op, 1 activate, 2 write, 3 block write, 4 load color, 5 load mask, and 6 and 7 act as no-ops. A write (2) stores `wdata` into column `col_addr`, and `rd_data` shows the new value in the cycle after that edge.
- R3: For both write kinds, a byte lane `l` (bits 8l+7..8l) whose `dqm[l]` is 1 keeps its old value in every column.
- R4: A block write (3) touches only columns 8*`col_addr[7:3]` to 8*`col_addr[7:3]`+7. `col_addr[2:0]` is ignored, and every other column is unchanged.
- R5: During a block write, bit 8l+k of `wdata` enables byte lane `l` of column k of the group, and an enabled lane receives the color register's lane `l`. When `wdata` is all zeros, nothing changes.
- R6: Load color (4) and load mask (5) copy `wdata` into the color register and the mask register, with no effect on `dqm`.
- R7: An activate (1) latches `act_pwm`. While the latched value is 1, a write or a block write changes only the bits at positions where the mask register holds 1. While it is 0, the mask register is ignored.
- R8: No-op commands leave every column unchanged, whatever `wdata`, `col_addr` and `dqm` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd | input | 3 | Command code (see R2) |
| act_pwm | input | 1 | Per-bit masking request, sampled by activate |
| col_addr | input | 8 | Column address; bits 7:3 select the group for a block write |
| wdata | input | 32 | Write data, register load value, or block-write column enables |
| dqm | input | 4 | Byte-lane write masks, 1 blocks the lane |
| rd_col | input | 8 | Column to read back |
| rd_data | output | 32 | Contents of column `rd_col` |

## Verification
The bench builds the block with its default parameters: 256 columns, a 32-bit word, four byte lanes, eight-column groups and the per-bit mask variant enabled. With these values the first and last groups, including column 255, can be reached. The 8-bit lane-by-column enable pattern can be exercised fully, with lane masks combined. Both states of the latched masking flag can be applied to the same columns, so each masking source can be told apart from the others.

// File: rtl/blkwr_pkg.sv
package blkwr_pkg;
   typedef enum logic [2:0] {
      OP_NOP  = 3'd0,
      OP_ACT  = 3'd1,
      OP_WR   = 3'd2,
      OP_BLK  = 3'd3,
      OP_LDC  = 3'd4,
      OP_LDM  = 3'd5
   } blk_op_e;
endpackage

// File: rtl/blkwr_regs.sv
module blkwr_regs #(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [2:0]    cmd,
   input  logic          act_pwm,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] color_q,
   output logic [DW-1:0] mask_q,
   output logic          pwm_q
);
   import blkwr_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         color_q <= '0;
         mask_q  <= '1;
         pwm_q   <= 1'b0;
      end else begin
         case (cmd)
            OP_ACT:  pwm_q   <= act_pwm;
            OP_LDC:  color_q <= wdata;
            OP_LDM:  mask_q  <= wdata;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/blkwr_enables.sv
module blkwr_enables #(
   parameter int NCOLS  = 256,
   parameter int DW     = 32,
   parameter int LANES  = 4,
   parameter int BLK    = 8,
   parameter bit PWM_EN = 1'b1
) (
   input  logic [2:0]                     cmd,
   input  logic [$clog2(NCOLS)-1:0]       col_addr,
   input  logic [DW-1:0]                  wdata,
   input  logic [LANES-1:0]               dqm,
   input  logic [DW-1:0]                  color_q,
   input  logic [DW-1:0]                  mask_q,
   input  logic                           pwm_q,
   output logic [NCOLS-1:0][DW-1:0]       bwe,
   output logic [DW-1:0]                  wval
);
   import blkwr_pkg::*;

   localparam int CAW  = $clog2(NCOLS);
   localparam int LW   = DW / LANES;
   localparam int BLKW = $clog2(BLK);

   logic          is_wr;
   logic          is_blk;
   logic [DW-1:0] bitmask;

   assign is_wr  = (cmd == OP_WR);
   assign is_blk = (cmd == OP_BLK);
   assign wval   = is_blk ? color_q : wdata;

   generate
      if (PWM_EN) begin : g_pwm
         assign bitmask = pwm_q ? mask_q : '1;
      end else begin : g_nopwm
         logic unused_pwm;
         assign unused_pwm = pwm_q ^ (^mask_q);
         assign bitmask    = '1;
      end
   endgenerate

   for (genvar c = 0; c < NCOLS; c++) begin : g_col
      localparam int K   = c % BLK;
      localparam int GRP = c / BLK;
      logic sel_col;
      logic in_grp;
      assign sel_col = (col_addr == CAW'(c));
      assign in_grp  = (col_addr[CAW-1:BLKW] == (CAW-BLKW)'(GRP));
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         logic lane_en;
         assign lane_en = ~dqm[l] &
                          ((is_wr & sel_col) | (is_blk & in_grp & wdata[l*LW+K]));
         assign bwe[c][l*LW +: LW] = {LW{lane_en}} & bitmask[l*LW +: LW];
      end
   end
endmodule

// File: rtl/blkwr_row.sv
module blkwr_row #(
   parameter int NCOLS = 256,
   parameter int DW    = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NCOLS-1:0][DW-1:0]   bwe,
   input  logic [DW-1:0]              wval,
   input  logic [$clog2(NCOLS)-1:0]   rd_col,
   output logic [DW-1:0]              rd_data
);
   logic [DW-1:0] cells [NCOLS];

   for (genvar c = 0; c < NCOLS; c++) begin : g_cell
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) cells[c] <= '0;
         else        cells[c] <= (cells[c] & ~bwe[c]) | (wval & bwe[c]);
      end
   end

   assign rd_data = cells[rd_col];
endmodule

// File: rtl/blkwr_engine.sv
module blkwr_engine #(
   parameter int NCOLS  = 256,
   parameter int DW     = 32,
   parameter int LANES  = 4,
   parameter int BLK    = 8,
   parameter bit PWM_EN = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [2:0]                cmd,
   input  logic                      act_pwm,
   input  logic [$clog2(NCOLS)-1:0]  col_addr,
   input  logic [DW-1:0]             wdata,
   input  logic [LANES-1:0]          dqm,
   input  logic [$clog2(NCOLS)-1:0]  rd_col,
   output logic [DW-1:0]             rd_data
);
   localparam int LW = DW / LANES;

   generate
      if (DW % LANES != 0) begin : g_bad_lanes
         $error("blkwr_engine: DW must split evenly into LANES");
      end
      if (LW != BLK) begin : g_bad_blk
         $error("blkwr_engine: lane width must equal BLK");
      end
      if ((NCOLS % BLK != 0) || (NCOLS != (1 << $clog2(NCOLS)))) begin : g_bad_cols
         $error("blkwr_engine: NCOLS must be a power of two and a multiple of BLK");
      end
   endgenerate

   logic [DW-1:0]            color_q;
   logic [DW-1:0]            mask_q;
   logic                     pwm_q;
   logic [NCOLS-1:0][DW-1:0] bwe;
   logic [DW-1:0]            wval;

   blkwr_regs #(.DW(DW)) u_regs (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .act_pwm(act_pwm), .wdata(wdata),
      .color_q(color_q), .mask_q(mask_q), .pwm_q(pwm_q)
   );

   blkwr_enables #(.NCOLS(NCOLS), .DW(DW), .LANES(LANES), .BLK(BLK), .PWM_EN(PWM_EN)) u_en (
      .cmd(cmd), .col_addr(col_addr), .wdata(wdata), .dqm(dqm),
      .color_q(color_q), .mask_q(mask_q), .pwm_q(pwm_q), .bwe(bwe), .wval(wval)
   );

   blkwr_row #(.NCOLS(NCOLS), .DW(DW)) u_row (
      .clk(clk), .rst_n(rst_n), .bwe(bwe), .wval(wval), .rd_col(rd_col), .rd_data(rd_data)
   );
endmodule

// File: rtl/blkwr_engine_chk.sv
module blkwr_engine_chk #(
   parameter int NCOLS = 256,
   parameter int DW    = 32,
   parameter int LANES = 4,
   parameter int BLK   = 8
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [2:0]                cmd,
   input logic [$clog2(NCOLS)-1:0]  col_addr,
   input logic [DW-1:0]             wdata,
   input logic [LANES-1:0]          dqm,
   input logic [$clog2(NCOLS)-1:0]  rd_col,
   input logic [DW-1:0]             rd_data,
   input logic [DW-1:0]             color_q,
   input logic                      pwm_q
);
   localparam int CAW  = $clog2(NCOLS);
   localparam int BLKW = $clog2(BLK);

   assert_full_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == 3'd2 && dqm == '0 && !pwm_q && rd_col == col_addr)
      |=> (rd_col != $past(rd_col)) || (rd_data == $past(wdata)));

   assert_lanes_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((cmd == 3'd2 || cmd == 3'd3) && dqm == '1)
      |=> (rd_col != $past(rd_col)) || (rd_data == $past(rd_data)));

   assert_outside_group_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == 3'd3 && rd_col[CAW-1:BLKW] != col_addr[CAW-1:BLKW])
      |=> (rd_col != $past(rd_col)) || (rd_data == $past(rd_data)));

   assert_empty_colmask_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == 3'd3 && wdata == '0)
      |=> (rd_col != $past(rd_col)) || (rd_data == $past(rd_data)));

   assert_color_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == 3'd4) |=> (color_q == $past(wdata)));

   assert_nop_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == 3'd0)
      |=> (rd_col != $past(rd_col)) || (rd_data == $past(rd_data)));
endmodule

bind blkwr_engine blkwr_engine_chk #(.NCOLS(NCOLS), .DW(DW), .LANES(LANES), .BLK(BLK)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd(cmd), .col_addr(col_addr), .wdata(wdata), .dqm(dqm),
   .rd_col(rd_col), .rd_data(rd_data), .color_q(color_q), .pwm_q(pwm_q)
);

// File: tb/blkwr_engine_bench.sv
`timescale 1ns/1ps
module blkwr_engine_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  cmd = 3'd0;
   logic        act_pwm = 1'b0;
   logic [7:0]  col_addr = '0;
   logic [31:0] wdata = '0;
   logic [3:0]  dqm = '0;
   logic [7:0]  rd_col = '0;
   logic [31:0] rd_data;

   int vecs = 0;
   int bad  = 0;
   bit done = 1'b0;

   logic [31:0] exp_row [256];
   logic [31:0] m_color;
   logic [31:0] m_mask;
   bit          m_pwm;

   always #2.5 clk = ~clk;

   blkwr_engine u_blkwr_engine (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .act_pwm(act_pwm), .col_addr(col_addr),
      .wdata(wdata), .dqm(dqm), .rd_col(rd_col), .rd_data(rd_data)
   );

   task automatic model(input logic [2:0] op, input logic [7:0] a,
                        input logic [31:0] d, input logic [3:0] m, input bit ap);
      case (op)
         3'd1: m_pwm = ap;
         3'd4: m_color = d;
         3'd5: m_mask = d;
         3'd2: begin
            for (int b = 0; b < 32; b++)
               if (!m[b/8] && (!m_pwm || m_mask[b])) exp_row[a][b] = d[b];
         end
         3'd3: begin
            for (int k = 0; k < 8; k++)
               for (int b = 0; b < 32; b++)
                  if (!m[b/8] && d[(b/8)*8+k] && (!m_pwm || m_mask[b]))
                     exp_row[{a[7:3], 3'(k)}][b] = m_color[b];
         end
         default: ;
      endcase
   endtask

   task automatic issue(input logic [2:0] op, input logic [7:0] a,
                        input logic [31:0] d, input logic [3:0] m, input bit ap);
      @(negedge clk);
      cmd = op; col_addr = a; wdata = d; dqm = m; act_pwm = ap;
      @(negedge clk);
      cmd = 3'd0; wdata = '0; dqm = '0; act_pwm = 1'b0;
      model(op, a, d, m, ap);
   endtask

   task automatic check_col(input int c, input string req);
      rd_col = 8'(c);
      #0.5;
      vecs++;
      if (rd_data !== exp_row[c]) begin
         bad++;
         $display("FAIL %s col %0d: got %h expected %h", req, c, rd_data, exp_row[c]);
      end
   endtask

   task automatic check_all(input string req);
      for (int c = 0; c < 256; c++) check_col(c, req);
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int c = 0; c < 256; c++) exp_row[c] = '0;
      m_color = '0; m_mask = '1; m_pwm = 1'b0;
      check_all("R1 reset contents");
      issue(3'd1, 8'd0, '0, '0, 1'b1);
      issue(3'd2, 8'd200, 32'hDEADBEEF, '0, 1'b0);
      check_col(200, "R1 reset mask all ones");
      issue(3'd3, 8'd16, 32'hFFFFFFFF, '0, 1'b0);
      check_col(17, "R1 reset color zero");
      issue(3'd1, 8'd0, '0, '0, 1'b0);
   endtask

   task automatic t_normal;
      issue(3'd2, 8'd5, 32'hA5A5A5A5, 4'b0000, 1'b0);
      check_col(5, "R2 full write");
      issue(3'd2, 8'd5, 32'h11223344, 4'b0101, 1'b0);
      check_col(5, "R3 lane mask on write");
      issue(3'd2, 8'd255, 32'h0BADF00D, 4'b0000, 1'b0);
      check_col(255, "R2 last column");
      issue(3'd6, 8'd5, 32'hFFFFFFFF, 4'b0000, 1'b0);
      check_col(5, "R2 code 6 is no-op");
   endtask

   task automatic t_block;
      issue(3'd4, 8'd0, 32'hC0FFEE11, 4'hF, 1'b0);
      issue(3'd5, 8'd0, 32'hFFFF0000, 4'hF, 1'b0);
      issue(3'd3, 8'h2B, 32'hFFFFFFFF, 4'b0000, 1'b0);
      for (int c = 40; c < 48; c++) check_col(c, "R4 R6 group filled with color");
      check_col(39, "R4 below group");
      check_col(48, "R4 above group");
      issue(3'd3, 8'h30, 32'hFF800201, 4'b1000, 1'b0);
      for (int c = 48; c < 56; c++) check_col(c, "R5 R3 column mask");
      issue(3'd3, 8'hFF, 32'h0F0F0F0F, 4'b0000, 1'b0);
      for (int c = 248; c < 256; c++) check_col(c, "R4 last group");
      issue(3'd3, 8'h28, 32'h00000000, 4'b0000, 1'b0);
      check_all("R5 empty column mask");
      issue(3'd3, 8'h28, 32'hFFFFFFFF, 4'b1111, 1'b0);
      check_all("R3 block all lanes masked");
   endtask

   task automatic t_pwm;
      issue(3'd1, 8'd0, '0, '0, 1'b1);
      issue(3'd2, 8'd5, 32'h12345678, 4'b0000, 1'b0);
      check_col(5, "R7 per-bit mask write");
      issue(3'd4, 8'd0, 32'h55AA55AA, 4'b0000, 1'b0);
      issue(3'd3, 8'h28, 32'hFFFFFFFF, 4'b0000, 1'b0);
      for (int c = 40; c < 48; c++) check_col(c, "R7 per-bit mask block write");
      issue(3'd5, 8'd0, 32'h0000F00F, 4'b0000, 1'b0);
      issue(3'd2, 8'd200, 32'h00000000, 4'b0010, 1'b0);
      check_col(200, "R7 R3 bit and lane masks");
      issue(3'd1, 8'd0, '0, '0, 1'b0);
      issue(3'd2, 8'd5, 32'h87654321, 4'b0000, 1'b0);
      check_col(5, "R7 mask ignored when off");
   endtask

   task automatic t_nop;
      @(negedge clk);
      cmd = 3'd0; col_addr = 8'd5; wdata = 32'hFFFFFFFF; dqm = 4'b0000;
      repeat (4) @(negedge clk);
      cmd = 3'd7;
      @(negedge clk);
      cmd = 3'd0; wdata = '0;
      check_all("R8 no-op stability");
   endtask

   initial begin
      t_reset();
      t_normal();
      t_block();
      t_pwm();
      t_nop();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      end
      $finish;
   end

   initial begin
      #(5ns * 100000);
      if (!done) begin
         done = 1'b1;
         bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      end
      $finish;
   end
endmodule